// File: doc/BRIEF.md
# ECC Error Capture and Reporting Registers

This block sits next to the ECC checker of a DRAM controller and records what the checker reports. Each error event carries a single-bit flag, a multi-bit flag, the 64-bit data word, the check bits and the 64-bit address of the access. When an event raises a detect flag and no other flag is pending, the block latches the failing data, check bits and address. Software reads these values through a small 32-bit register interface.

The block has per-type detection disables, per-type interrupt enables and a threshold counter for single-bit errors. With the counter, correctable errors raise a flag only after a programmed number of them have arrived. The detect flags are sticky, and software clears them by writing ones. The block also holds the masks for data and check-bit error injection and drives them to the controller.

Reads are combinational from `addr_i`. A write takes effect at the clock edge where `wr_en_i` is high.

Top module: `ecc_err_regs`

## Requirements
- R1: After reset every register reads zero, `irq_o` is 0 and the injection outputs are 0.
- R2: The detect register (index 0) holds a single-bit flag in bit 0 and a multi-bit flag in bit 1. An event that is not disabled sets the matching flag, and a reading of zero means nothing is pending.
- R3: A write to the detect register clears only the flags whose bits are 1 in the written value. A flag being set in the same cycle stays set.
- R4: When an event sets a flag while the detect register is zero, the block captures the data at index 4 (bits 63:32) and index 5 (bits 31:0), and the address at index 7 (bits 31:0) and index 8 (bits 63:32).
- R5: While any flag is pending, later events leave every capture register unchanged.
- R6: The captured check bits (index 6) keep only bits 7:0 when `narrow_bus_i` is 0, and bits 15:0 when it is 1.
- R7: The single-bit register (index 3) holds a threshold in bits 23:16, and bits 7:0 read back the running count. Each enabled single-bit event increments the count. When the count reaches the threshold, the single-bit flag is set and the count returns to 0. A threshold of 0 or 1 flags every event.
- R8: The disable register (index 1) suppresses single-bit detection with bit 0 and multi-bit detection with bit 1. A suppressed event changes no flag, no count and no capture.
- R9: The interrupt-enable register (index 2) uses bit 0 for single-bit and bit 1 for multi-bit. `irq_o` is high exactly when some flag is set and its enable bit is set.
- R10: The injection registers read back what was written. Index 9 is the high data mask, index 10 the low data mask and index 11 the check-bit control. `inj_data_o` is {index 9, index 10} and `inj_ctrl_o` is index 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| narrow_bus_i | input | 1 | 1 selects a 32-bit data bus, 0 selects a 64-bit data bus |
| err_valid_i | input | 1 | Error event strobe |
| err_sbe_i | input | 1 | Event is a single-bit error |
| err_mbe_i | input | 1 | Event is a multi-bit error |
| err_data_i | input | 64 | Data word of the failing access |
| err_ecc_i | input | 16 | Check bits of the failing access |
| err_addr_i | input | 64 | Address of the failing access |
| inj_data_o | output | 64 | Data injection mask |
| inj_ctrl_o | output | 32 | Check-bit injection control |
| irq_o | output | 1 | Error interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit count and threshold, 16 check bits and a 64-bit data path and address. With an 8-bit threshold, values of 0, 1 and 3 can be reached within a few events. That lets the bench check the below-threshold count read-back, the reset of the count on a hit, and the treatment of zero as one. The 16-bit check-bit width puts both masking modes within reach with a single 0xBEEF pattern.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  localparam int REG_AW = 4;
  localparam int FLAG_SBE = 0;
  localparam int FLAG_MBE = 1;

  typedef enum logic [REG_AW-1:0] {
    IDX_DETECT  = 4'd0,
    IDX_DISABLE = 4'd1,
    IDX_INT_EN  = 4'd2,
    IDX_SBE     = 4'd3,
    IDX_CAP_DHI = 4'd4,
    IDX_CAP_DLO = 4'd5,
    IDX_CAP_ECC = 4'd6,
    IDX_CAP_ALO = 4'd7,
    IDX_CAP_AHI = 4'd8,
    IDX_INJ_DHI = 4'd9,
    IDX_INJ_DLO = 4'd10,
    IDX_INJ_CTL = 4'd11
  } reg_idx_e;
endpackage

// File: rtl/ecc_sbe_thresh.sv
module ecc_sbe_thresh #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   nxt;
  logic [CNT_W-1:0] eff_thr;

  assign nxt     = {1'b0, cnt_q} + 1'b1;
  assign eff_thr = (thr_i == '0) ? CNT_W'(1) : thr_i;
  assign hit_o   = event_i && (nxt >= {1'b0, eff_thr});
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (event_i) cnt_q <= hit_o ? '0 : nxt[CNT_W-1:0];
  end

  a_r7_count_clears_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cnt_q == '0);
  a_r7_idle_holds_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !event_i |=> $stable(cnt_q));
endmodule

// File: rtl/ecc_cap_bank.sv
module ecc_cap_bank #(
  parameter int DATA_W = 64,
  parameter int ECC_W  = 16,
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              narrow_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ECC_W-1:0]  ecc_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o,
  output logic [ECC_W-1:0]  ecc_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int WIDE_ECC = ECC_W / 2;

  logic [ECC_W-1:0] ecc_m;

  // upper half of the check bits only carries meaning on a narrow bus
  for (genvar i = 0; i < ECC_W; i++) begin : g_mask
    if (i < WIDE_ECC) begin : g_lo
      assign ecc_m[i] = ecc_i[i];
    end else begin : g_hi
      assign ecc_m[i] = ecc_i[i] & narrow_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      ecc_o  <= '0;
      addr_o <= '0;
    end else if (load_i) begin
      data_o <= data_i;
      ecc_o  <= ecc_m;
      addr_o <= addr_i;
    end
  end

  a_r5_hold_without_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(data_o) && $stable(ecc_o) && $stable(addr_o));
  a_r6_wide_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !narrow_i |=> ecc_o[ECC_W-1:WIDE_ECC] == '0);
endmodule

// File: rtl/ecc_err_regs.sv
module ecc_err_regs
  import ecc_err_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ECC_W  = 16,
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              narrow_bus_i,
  input  logic              err_valid_i,
  input  logic              err_sbe_i,
  input  logic              err_mbe_i,
  input  logic [DATA_W-1:0] err_data_i,
  input  logic [ECC_W-1:0]  err_ecc_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  output logic [DATA_W-1:0] inj_data_o,
  output logic [31:0]       inj_ctrl_o,
  output logic              irq_o
);
  localparam int HALF = 32;
  localparam int THR_LSB = 16;

  logic [1:0]        det_q, det_d, dis_q, ien_q, set_vec, clr_vec;
  logic [CNT_W-1:0]  thr_q, cnt;
  logic [HALF-1:0]   inj_hi_q, inj_lo_q, inj_ctl_q;
  logic              sbe_ev, mbe_ev, sbe_hit, cap_load;
  logic [DATA_W-1:0] cap_data;
  logic [ECC_W-1:0]  cap_ecc;
  logic [ADDR_W-1:0] cap_addr;

  function automatic logic wr_hit(input logic [REG_AW-1:0] a, input reg_idx_e idx);
    return a == idx;
  endfunction

  assign sbe_ev = err_valid_i && err_sbe_i && !dis_q[FLAG_SBE];
  assign mbe_ev = err_valid_i && err_mbe_i && !dis_q[FLAG_MBE];

  ecc_sbe_thresh #(.CNT_W(CNT_W)) u_thresh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .event_i(sbe_ev),
    .thr_i  (thr_q),
    .hit_o  (sbe_hit),
    .cnt_o  (cnt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLAG_SBE] = sbe_hit;
    set_vec[FLAG_MBE] = mbe_ev;
    clr_vec = (wr_en_i && wr_hit(addr_i, IDX_DETECT)) ? wdata_i[1:0] : 2'b00;
    det_d   = (det_q & ~clr_vec) | set_vec;
  end

  // first error wins: capture only from an idle detect register
  assign cap_load = (set_vec != '0) && (det_q == '0);

  ecc_cap_bank #(.DATA_W(DATA_W), .ECC_W(ECC_W), .ADDR_W(ADDR_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cap_load),
    .narrow_i(narrow_bus_i),
    .data_i  (err_data_i),
    .ecc_i   (err_ecc_i),
    .addr_i  (err_addr_i),
    .data_o  (cap_data),
    .ecc_o   (cap_ecc),
    .addr_o  (cap_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q     <= '0;
      dis_q     <= '0;
      ien_q     <= '0;
      thr_q     <= '0;
      inj_hi_q  <= '0;
      inj_lo_q  <= '0;
      inj_ctl_q <= '0;
    end else begin
      det_q <= det_d;
      if (wr_en_i) begin
        if (wr_hit(addr_i, IDX_DISABLE)) dis_q     <= wdata_i[1:0];
        if (wr_hit(addr_i, IDX_INT_EN))  ien_q     <= wdata_i[1:0];
        if (wr_hit(addr_i, IDX_SBE))     thr_q     <= wdata_i[THR_LSB +: CNT_W];
        if (wr_hit(addr_i, IDX_INJ_DHI)) inj_hi_q  <= wdata_i;
        if (wr_hit(addr_i, IDX_INJ_DLO)) inj_lo_q  <= wdata_i;
        if (wr_hit(addr_i, IDX_INJ_CTL)) inj_ctl_q <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      IDX_DETECT:  rdata_o = {30'd0, det_q};
      IDX_DISABLE: rdata_o = {30'd0, dis_q};
      IDX_INT_EN:  rdata_o = {30'd0, ien_q};
      IDX_SBE:     rdata_o = (32'(thr_q) << THR_LSB) | 32'(cnt);
      IDX_CAP_DHI: rdata_o = cap_data[DATA_W-1:HALF];
      IDX_CAP_DLO: rdata_o = cap_data[HALF-1:0];
      IDX_CAP_ECC: rdata_o = 32'(cap_ecc);
      IDX_CAP_ALO: rdata_o = cap_addr[HALF-1:0];
      IDX_CAP_AHI: rdata_o = cap_addr[ADDR_W-1:HALF];
      IDX_INJ_DHI: rdata_o = inj_hi_q;
      IDX_INJ_DLO: rdata_o = inj_lo_q;
      IDX_INJ_CTL: rdata_o = inj_ctl_q;
      default:     rdata_o = '0;
    endcase
  end

  assign inj_data_o = {inj_hi_q, inj_lo_q};
  assign inj_ctrl_o = inj_ctl_q;
  assign irq_o      = |(det_q & ien_q);

  a_r3_sbe_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_q[FLAG_SBE] && !(wr_en_i && addr_i == IDX_DETECT && wdata_i[FLAG_SBE]) |=> det_q[FLAG_SBE]);
  a_r3_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbe_ev |=> det_q[FLAG_MBE]);
  a_r8_mbe_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_i && dis_q[FLAG_MBE] && !det_q[FLAG_MBE] |=> !det_q[FLAG_MBE]);
  a_r9_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ien_q != '0) && (det_q != '0));
endmodule

// File: tb/ecc_err_regs_test.sv
module ecc_err_regs_test;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        wr_en_i = 0;
  logic [3:0]  addr_i = 0;
  logic [31:0] wdata_i = 0;
  logic [31:0] rdata_o;
  logic        narrow_bus_i = 0;
  logic        err_valid_i = 0, err_sbe_i = 0, err_mbe_i = 0;
  logic [63:0] err_data_i = 0;
  logic [15:0] err_ecc_i = 0;
  logic [63:0] err_addr_i = 0;
  logic [63:0] inj_data_o;
  logic [31:0] inj_ctrl_o;
  logic        irq_o;

  int checks = 0, failures = 0;

  always #2 clk_i = ~clk_i;

  ecc_err_regs uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic ev(input logic s, input logic m, input logic [63:0] d,
                    input logic [15:0] e, input logic [63:0] ad);
    @(negedge clk_i);
    err_valid_i = 1; err_sbe_i = s; err_mbe_i = m;
    err_data_i = d; err_ecc_i = e; err_addr_i = ad;
    @(negedge clk_i);
    err_valid_i = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R1 detect", v, 0);
    rd(3, v); chk("R1 sbe reg", v, 0);
    rd(5, v); chk("R1 cap lo", v, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 inj", inj_data_o, 0);
  endtask

  task automatic t_inject();
    logic [31:0] v;
    wr(9, 32'hA5A5_0001); wr(10, 32'h0F0F_1234); wr(11, 32'h0000_00C3);
    rd(9, v);  chk("R10 inj hi", v, 32'hA5A5_0001);
    rd(10, v); chk("R10 inj lo", v, 32'h0F0F_1234);
    rd(11, v); chk("R10 inj ctl", v, 32'h0000_00C3);
    chk("R10 inj_data_o", inj_data_o, 64'hA5A5_0001_0F0F_1234);
    chk("R10 inj_ctrl_o", inj_ctrl_o, 32'hC3);
  endtask

  task automatic t_mbe_capture();
    logic [31:0] v;
    narrow_bus_i = 0;
    ev(0, 1, 64'h1122_3344_5566_7788, 16'hBEEF, 64'h0000_0012_8000_0040);
    rd(0, v); chk("R2 mbe flag", v, 2);
    rd(4, v); chk("R4 cap dhi", v, 32'h1122_3344);
    rd(5, v); chk("R4 cap dlo", v, 32'h5566_7788);
    rd(7, v); chk("R4 cap alo", v, 32'h8000_0040);
    rd(8, v); chk("R4 cap ahi", v, 32'h0000_0012);
    rd(6, v); chk("R6 wide ecc", v, 32'h0000_00EF);
    chk("R9 irq disabled", irq_o, 0);
    wr(2, 2);
    chk("R9 irq enabled", irq_o, 1);
  endtask

  task automatic t_preserve_and_clear();
    logic [31:0] v;
    ev(1, 1, 64'hDEAD_0000_BEEF_0000, 16'h0011, 64'h1);
    rd(5, v); chk("R5 cap dlo held", v, 32'h5566_7788);
    rd(7, v); chk("R5 cap alo held", v, 32'h8000_0040);
    wr(0, 32'h1);
    rd(0, v); chk("R3 partial clear", v, 2);
    chk("R9 irq still", irq_o, 1);
    wr(0, 32'h2);
    rd(0, v); chk("R3 clear mbe", v, 0);
    chk("R9 irq cleared", irq_o, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    @(negedge clk_i);
    wr_en_i = 1; addr_i = 0; wdata_i = 32'hFFFF_FFFF;
    err_valid_i = 1; err_sbe_i = 0; err_mbe_i = 1;
    err_data_i = 64'hCAFE_F00D_0000_0001; err_ecc_i = 16'h1234; err_addr_i = 64'h40;
    @(negedge clk_i);
    wr_en_i = 0; err_valid_i = 0;
    rd(0, v); chk("R3 set beats clear", v, 2);
    rd(5, v); chk("R4 cap on set", v, 32'h0000_0001);
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R3 clear all", v, 0);
  endtask

  task automatic t_threshold();
    logic [31:0] v;
    narrow_bus_i = 1;
    wr(3, 32'h0003_0000); wr(2, 3);
    ev(1, 0, 64'h1, 16'h1, 64'h10);
    ev(1, 0, 64'h2, 16'h2, 64'h20);
    rd(0, v); chk("R7 below threshold", v, 0);
    rd(3, v); chk("R7 count read", v, 32'h0003_0002);
    chk("R7 no irq", irq_o, 0);
    ev(1, 0, 64'h3333_0000_0000_0003, 16'hBEEF, 64'h30);
    rd(0, v); chk("R7 threshold hit", v, 1);
    rd(3, v); chk("R7 count reset", v, 32'h0003_0000);
    chk("R9 sbe irq", irq_o, 1);
    rd(6, v); chk("R6 narrow ecc", v, 32'h0000_BEEF);
    rd(4, v); chk("R4 third event dhi", v, 32'h3333_0000);
    wr(0, 1);
    wr(3, 0);
    ev(1, 0, 64'h4, 16'h0, 64'h40);
    rd(0, v); chk("R7 zero threshold", v, 1);
    wr(0, 1);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    wr(1, 3);
    ev(1, 1, 64'h9999_9999_9999_9999, 16'h99, 64'h99);
    rd(0, v); chk("R8 no flag", v, 0);
    rd(3, v); chk("R8 no count", v, 0);
    rd(5, v); chk("R8 no capture", v, 32'h0000_0004);
    chk("R8 no irq", irq_o, 0);
    wr(1, 0);
    ev(0, 1, 64'h5, 16'h0, 64'h0);
    rd(0, v); chk("R8 reenabled", v, 2);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_inject();
    t_mbe_capture();
    t_preserve_and_clear();
    t_set_wins();
    t_threshold();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule